// File: doc/BRIEF.md
# Double-Rate Two-Word Burst SRAM Core

This block is a synchronous pipelined memory with a double-data-rate interface that moves two words per access. It runs from one internal clock at twice the command rate. An internal phase bit splits each command period into a K half and a K# half. Read and write requests are taken only on K edges, one request per edge. Every request carries a pair address, and two data words then move one after the other on the data bus.

Storage is split into two banks, one holding the even word of each pair and one holding the odd word. A write is kept in a staging register until the next K edge after its second data beat, and only then written into the banks. A read of a word that is still in staging gets the staged bytes, so every read sees the most recent write issued before it.

Two things are set for each instance or pin. The first is the burst start: either always the even word, or taken from the address LSB. The second is the read latency: one and a half command periods, or one.

Top module: `ddr2w_sram`

## Requirements
- R1: Requests are sampled only on K edges, which are the clock edges taken while `k_phase` is 0. At most one request is accepted per K edge. When `rd_req` and `wr_req` are both high, only the read is performed and the memory is left unchanged.
- R2: A write accepted at K edge t takes its first data word from `din` at the following K# edge (t+1 clocks) and its second data word at the next K edge (t+2 clocks).
- R3: `ben` is sampled with each data beat. Bit i enables byte i, which is bits [8i+7:8i] of the word. Bytes whose enable is 0 keep their previous contents.
- R4: With WIDE=1, `addr[0]` selects the word transferred first. The second beat uses the other word of the same pair, so a burst that starts at LSB 1 wraps back to LSB 0.
- R5: With WIDE=0, `addr[0]` is ignored. The first beat always uses word {addr[PAIR_W:1],0} and the second beat uses word {addr[PAIR_W:1],1}.
- R6: For a read accepted at K edge t, the first word is on `dout` with `dvalid` high for the clock cycle after edge t+3 when `lat_short`=0, or after edge t+2 when `lat_short`=1. The second word follows in the next clock cycle.
- R7: A read returns data that includes every write accepted before it, even a write not yet committed to the banks. A write accepted after the read does not affect that read's data.
- R8: `dvalid` is high only during read beats. `echo` toggles in every cycle where `dvalid` is high and holds its value otherwise.
- R9: During reset, `dvalid`, `echo` and `k_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_short | input | 1 | 1 selects one-period read latency, 0 selects one and a half periods |
| rd_req | input | 1 | Read request, sampled on K edges |
| wr_req | input | 1 | Write request, sampled on K edges |
| addr | input | PAIR_W+1 | Word address; the LSB is the burst start in the wide configuration |
| din | input | NBYTES*BYTE_W | Write data beats |
| ben | input | NBYTES | Byte enables for the current data beat, active high |
| k_phase | output | 1 | 0 when the next clock edge is a K edge |
| dout | output | NBYTES*BYTE_W | Read data beats |
| dvalid | output | 1 | High while `dout` carries a read beat |
| echo | output | 1 | Toggles with each valid read beat |

## Verification
The assertions assume that `lat_short` changes only when no read is in flight. If it changed while a read was in flight, the two beat slots could overlap. They also assume that each accepted write is followed by at least one more K period, so that its second beat is driven. The stimulus changes the latency mode only after several idle periods and ends every run with idle periods. Random traffic mixes reads, writes and simultaneous requests at random word addresses, including both start LSBs. A wide instance and a narrow instance share the same input pins, and each is compared against its own word-level model.

// File: rtl/ddr2w_pkg.sv
package ddr2w_pkg;
  typedef enum logic {
    LAT_LONG  = 1'b0,
    LAT_SHORT = 1'b1
  } lat_e;

  // word LSB of a burst beat: the start LSB, flipped for the second beat
  function automatic logic beat_lsb(input logic start, input logic beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/ddr2w_bank.sv
module ddr2w_bank #(
  parameter int AW = 5,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*BW-1:0] wdata,
  input  logic [NB-1:0]    wmask,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NB*BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && wmask[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ddr2w_wr_path.sv
module ddr2w_wr_path
  import ddr2w_pkg::*;
#(
  parameter int PW = 5,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  k_edge,
  input  logic                  wr_go,
  input  logic [PW-1:0]         wr_pair,
  input  logic                  wr_start,
  input  logic [NB*BW-1:0]      din,
  input  logic [NB-1:0]         ben,
  input  logic [PW-1:0]         q_pair,
  input  logic                  q_lsb,
  output logic                  fwd_hit,
  output logic [NB*BW-1:0]      fwd_data,
  output logic [NB-1:0]         fwd_mask,
  output logic                  cm_en,
  output logic [PW-1:0]         cm_pair,
  output logic [1:0][NB*BW-1:0] cm_data,
  output logic [1:0][NB-1:0]    cm_mask
);
  localparam int DW = NB * BW;

  logic                   cap_busy, cap_busy_d;
  logic                   b1_wait, b1_wait_d;
  logic                   stg_vld, stg_vld_d;
  logic [PW-1:0]          cap_pair;
  logic                   cap_start;
  logic [DW-1:0]          b0_d;
  logic [NB-1:0]          b0_m;
  logic [PW-1:0]          stg_pair;
  logic                   stg_start;
  logic [1:0][DW-1:0]     stg_d;
  logic [1:0][NB-1:0]     stg_m;
  logic                   beat0_ld, stg_ld;
  logic                   fwd_beat;

  // next-state decode
  always_comb begin
    beat0_ld   = cap_busy && !k_edge;
    stg_ld     = b1_wait && k_edge;
    cm_en      = stg_vld && k_edge;
    cap_busy_d = wr_go | (cap_busy & ~beat0_ld);
    b1_wait_d  = beat0_ld | (b1_wait & ~stg_ld);
    stg_vld_d  = stg_ld | (stg_vld & ~cm_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_busy <= 1'b0;
      b1_wait  <= 1'b0;
      stg_vld  <= 1'b0;
    end else begin
      cap_busy <= cap_busy_d;
      b1_wait  <= b1_wait_d;
      stg_vld  <= stg_vld_d;
    end
  end

  // data registers with explicit enables, no reset
  always_ff @(posedge clk) begin
    if (wr_go) begin
      cap_pair  <= wr_pair;
      cap_start <= wr_start;
    end
    if (beat0_ld) begin
      b0_d <= din;
      b0_m <= ben;
    end
    if (stg_ld) begin
      stg_pair  <= cap_pair;
      stg_start <= cap_start;
      stg_d[0]  <= b0_d;
      stg_m[0]  <= b0_m;
      stg_d[1]  <= din;
      stg_m[1]  <= ben;
    end
  end

  // bank k receives the beat whose word LSB equals k
  assign cm_pair = stg_pair;
  for (genvar k = 0; k < 2; k++) begin : g_cm
    logic sel;
    assign sel        = beat_lsb(stg_start, 1'(k));
    assign cm_data[k] = stg_d[sel];
    assign cm_mask[k] = stg_m[sel];
  end

  // staged write lookup for reads
  assign fwd_hit  = stg_vld && (stg_pair == q_pair);
  assign fwd_beat = beat_lsb(stg_start, q_lsb);
  assign fwd_data = stg_d[fwd_beat];
  assign fwd_mask = stg_m[fwd_beat];

  // R2: the first beat is captured on a K# edge, so a K edge comes next
  p_beat_kbar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    b1_wait |-> k_edge);

  // R7: a staged write is committed no later than the next K edge
  p_stage_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_vld && k_edge && !b1_wait) |=> !stg_vld);
endmodule

// File: rtl/ddr2w_rd_path.sv
module ddr2w_rd_path
  import ddr2w_pkg::*;
#(
  parameter int PW = 5,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  k_edge,
  input  logic                  rd_go,
  input  logic [PW-1:0]         rd_pair,
  input  logic                  rd_start,
  input  logic                  lat_short,
  output logic [PW-1:0]         q_pair,
  output logic                  q_lsb,
  input  logic [1:0][NB*BW-1:0] bank_rd,
  input  logic                  fwd_hit,
  input  logic [NB*BW-1:0]      fwd_data,
  input  logic [NB-1:0]         fwd_mask,
  output logic [NB*BW-1:0]      dout,
  output logic                  dvalid,
  output logic                  echo
);
  localparam int DW  = NB * BW;
  localparam int STG = 4;

  logic [STG-1:0]         tok_q, tok_d;
  logic [STG-1:0][PW-1:0] pr_q, pr_d;
  logic [STG-1:0]         st_q, st_d;
  logic [1:0]             i0;
  logic                   sel0, sel1, load;
  logic [DW-1:0]          merged, arr_word;

  // next-state: request token pipe and beat selection
  always_comb begin
    tok_d    = {tok_q[STG-2:0], rd_go};
    pr_d     = {pr_q[STG-2:0], rd_pair};
    st_d     = {st_q[STG-2:0], rd_start};
    i0       = (lat_short == LAT_SHORT) ? 2'd1 : 2'd2;
    sel0     = tok_q[i0];
    sel1     = tok_q[i0 + 2'd1];
    load     = sel0 | sel1;
    q_pair   = sel0 ? pr_q[i0] : pr_q[i0 + 2'd1];
    q_lsb    = sel0 ? beat_lsb(st_q[i0], 1'b0) : beat_lsb(st_q[i0 + 2'd1], 1'b1);
    arr_word = bank_rd[q_lsb];
    for (int b = 0; b < NB; b++) begin
      merged[b*BW +: BW] = (fwd_hit && fwd_mask[b]) ? fwd_data[b*BW +: BW]
                                                    : arr_word[b*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q  <= '0;
      dvalid <= 1'b0;
      echo   <= 1'b0;
    end else begin
      tok_q  <= tok_d;
      dvalid <= load;
      echo   <= echo ^ load;
    end
  end

  always_ff @(posedge clk) begin
    pr_q <= pr_d;
    st_q <= st_d;
    if (load) dout <= merged;
  end

  // R1: a read is only accepted on a K edge, so the K# half follows
  p_rd_on_k_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_q[0] |-> !k_edge);

  // R6: read beats always come in pairs
  p_beat_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) |=> dvalid);

  // R8: echo moves with every valid beat and holds otherwise
  p_echo_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> (echo != $past(echo)));
  p_echo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> $stable(echo));
endmodule

// File: rtl/ddr2w_sram.sv
module ddr2w_sram
  import ddr2w_pkg::*;
#(
  parameter int PAIR_W = 5,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  parameter bit WIDE   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lat_short,
  input  logic                     rd_req,
  input  logic                     wr_req,
  input  logic [PAIR_W:0]          addr,
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  logic [NBYTES-1:0]        ben,
  output logic                     k_phase,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dvalid,
  output logic                     echo
);
  localparam int DW = NBYTES * BYTE_W;

  logic [1:0]             rst_sync;
  logic                   rst_ni;
  logic                   k_edge, rd_go, wr_go, start_lsb;
  logic [PAIR_W-1:0]      q_pair, cm_pair;
  logic                   q_lsb, fwd_hit, cm_en;
  logic [DW-1:0]          fwd_data;
  logic [NBYTES-1:0]      fwd_mask;
  logic [1:0][DW-1:0]     cm_data, bank_rd;
  logic [1:0][NBYTES-1:0] cm_mask;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) k_phase <= 1'b0;
    else         k_phase <= ~k_phase;
  end

  // request decode: reads take priority on a shared K edge
  assign k_edge    = ~k_phase;
  assign rd_go     = k_edge & rd_req;
  assign wr_go     = k_edge & wr_req & ~rd_req;
  assign start_lsb = WIDE ? addr[0] : 1'b0;

  ddr2w_wr_path #(.PW(PAIR_W), .NB(NBYTES), .BW(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_ni), .k_edge(k_edge), .wr_go(wr_go),
    .wr_pair(addr[PAIR_W:1]), .wr_start(start_lsb), .din(din), .ben(ben),
    .q_pair(q_pair), .q_lsb(q_lsb), .fwd_hit(fwd_hit), .fwd_data(fwd_data),
    .fwd_mask(fwd_mask), .cm_en(cm_en), .cm_pair(cm_pair), .cm_data(cm_data),
    .cm_mask(cm_mask)
  );

  for (genvar k = 0; k < 2; k++) begin : g_bank
    ddr2w_bank #(.AW(PAIR_W), .NB(NBYTES), .BW(BYTE_W)) u_bank (
      .clk(clk), .we(cm_en), .waddr(cm_pair), .wdata(cm_data[k]),
      .wmask(cm_mask[k]), .raddr(q_pair), .rdata(bank_rd[k])
    );
  end

  ddr2w_rd_path #(.PW(PAIR_W), .NB(NBYTES), .BW(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_ni), .k_edge(k_edge), .rd_go(rd_go),
    .rd_pair(addr[PAIR_W:1]), .rd_start(start_lsb), .lat_short(lat_short),
    .q_pair(q_pair), .q_lsb(q_lsb), .bank_rd(bank_rd), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data), .fwd_mask(fwd_mask), .dout(dout), .dvalid(dvalid),
    .echo(echo)
  );

  // R1: reads and writes are never both accepted on one edge
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({rd_go, wr_go}));
endmodule

// File: tb/ddr2w_sram_tb_top.sv
module ddr2w_sram_tb_top;
  localparam int PW = 5;
  localparam int NW = 1 << (PW + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lat_short = 1'b0;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0;
  logic [1:0]  ben = '0;
  logic        kph_w, kph_n, dv_w, dv_n, ec_w, ec_n;
  logic [15:0] do_w, do_n;

  int checks = 0, failures = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  logic [15:0] mw [NW];
  logic [15:0] mn [NW];
  logic [15:0] exp_d [int];
  string       exp_t [int];
  logic [1:0]  ep;
  logic [15:0] nx_d;
  logic [1:0]  nx_m;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2w_sram #(.PAIR_W(PW), .WIDE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .lat_short(lat_short), .rd_req(rd_req), .wr_req(wr_req),
    .addr(addr), .din(din), .ben(ben), .k_phase(kph_w), .dout(do_w), .dvalid(dv_w), .echo(ec_w));

  ddr2w_sram #(.PAIR_W(PW), .WIDE(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .lat_short(lat_short), .rd_req(rd_req), .wr_req(wr_req),
    .addr(addr), .din(din), .ben(ben), .k_phase(kph_n), .dout(do_n), .dvalid(dv_n), .echo(ec_n));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] m);
    logic [15:0] r = old;
    if (m[0]) r[7:0]  = d[7:0];
    if (m[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  // one K period: op 0 idle, 1 read, 2 write, 3 both requests
  task automatic kcyc(input int op, input logic [5:0] a, input logic [15:0] d0,
                      input logic [15:0] d1, input logic [1:0] m0, input logic [1:0] m1,
                      input string tag);
    int c0, l;
    int w0, w1, n0, n1;
    @(negedge clk);
    rd_req = (op == 1 || op == 3);
    wr_req = (op == 2 || op == 3);
    addr = a;
    din = nx_d;
    ben = nx_m;
    c0 = cyc + 1;
    l  = lat_short ? 2 : 3;
    w0 = int'(a); w1 = int'(a ^ 6'd1);
    n0 = int'({a[5:1], 1'b0}); n1 = n0 + 1;
    if (op == 1 || op == 3) begin
      exp_d[(c0 + l) * 2]         = mw[w0];
      exp_d[(c0 + l + 1) * 2]     = mw[w1];
      exp_d[(c0 + l) * 2 + 1]     = mn[n0];
      exp_d[(c0 + l + 1) * 2 + 1] = mn[n1];
      exp_t[(c0 + l) * 2] = tag;     exp_t[(c0 + l + 1) * 2] = tag;
      exp_t[(c0 + l) * 2 + 1] = tag; exp_t[(c0 + l + 1) * 2 + 1] = tag;
    end else if (op == 2) begin
      mw[w0] = merge(mw[w0], d0, m0); mw[w1] = merge(mw[w1], d1, m1);
      mn[n0] = merge(mn[n0], d0, m0); mn[n1] = merge(mn[n1], d1, m1);
    end
    @(negedge clk);
    rd_req = 1'b0;
    wr_req = 1'b0;
    if (op == 2) begin
      din = d0; ben = m0; nx_d = d1; nx_m = m1;
    end else begin
      din = 16'($urandom); ben = 2'($urandom);
      nx_d = 16'($urandom); nx_m = 2'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(0, '0, '0, '0, '0, '0, "R8");
  endtask

  task automatic rnd_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r = int'($urandom % 8);
      int op = (r < 3) ? 1 : (r < 6) ? 2 : (r == 6) ? 0 : 3;
      kcyc(op, 6'($urandom), 16'($urandom), 16'($urandom),
           2'($urandom), 2'($urandom), (op == 3) ? "R1" : "R6");
    end
  endtask

  // output checker, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      for (int k = 0; k < 2; k++) begin
        logic v, e;
        logic [15:0] d;
        int key;
        v = (k == 0) ? dv_w : dv_n;
        e = (k == 0) ? ec_w : ec_n;
        d = (k == 0) ? do_w : do_n;
        key = cyc * 2 + k;
        if (exp_d.exists(key)) begin
          check(v === 1'b1 && d === exp_d[key], exp_t[key],
                (k == 0) ? "wide read beat" : "narrow read beat",
                {15'd0, v, d}, {16'd1, exp_d[key]});
          check(e !== ep[k], "R8", "echo toggle", {31'd0, e}, {31'd0, ~ep[k]});
          exp_d.delete(key);
          exp_t.delete(key);
        end else begin
          check(v === 1'b0 && e === ep[k], "R8", "idle valid/echo",
                {30'd0, v, e}, {30'd0, 1'b0, ep[k]});
        end
        ep[k] = e;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    nx_d = '0; nx_m = '0;
    repeat (4) @(negedge clk);
    check(dv_w === 1'b0 && ec_w === 1'b0 && kph_w === 1'b0, "R9", "wide reset",
          {29'd0, dv_w, ec_w, kph_w}, 32'd0);
    check(dv_n === 1'b0 && ec_n === 1'b0 && kph_n === 1'b0, "R9", "narrow reset",
          {29'd0, dv_n, ec_n, kph_n}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    while (kph_w !== 1'b1) @(negedge clk);
    ep[0] = ec_w; ep[1] = ec_n;
    chk_on = 1;

    // fill every pair with full-enable writes
    for (int p = 0; p < NW / 2; p++)
      kcyc(2, 6'(p * 2), 16'hA000 + 16'(p * 2), 16'hA001 + 16'(p * 2), 2'b11, 2'b11, "R2");
    idle(3);

    // long latency directed cases
    kcyc(1, 6'd4, '0, '0, '0, '0, "R6");
    kcyc(1, 6'd5, '0, '0, '0, '0, "R4 R5");
    kcyc(2, 6'd9, 16'h1111, 16'h2222, 2'b11, 2'b11, "R2");
    kcyc(1, 6'd9, '0, '0, '0, '0, "R2 R7");
    kcyc(1, 6'd8, '0, '0, '0, '0, "R7");
    kcyc(1, 6'd12, '0, '0, '0, '0, "R7");
    kcyc(2, 6'd12, 16'h3333, 16'h4444, 2'b11, 2'b11, "R7");
    kcyc(1, 6'd13, '0, '0, '0, '0, "R7");
    kcyc(2, 6'd20, 16'h5A5A, 16'hC3C3, 2'b01, 2'b10, "R3");
    idle(1);
    kcyc(1, 6'd20, '0, '0, '0, '0, "R3");
    kcyc(3, 6'd30, 16'hDEAD, 16'hBEEF, 2'b11, 2'b11, "R1");
    kcyc(1, 6'd30, '0, '0, '0, '0, "R1");
    kcyc(1, 6'd31, '0, '0, '0, '0, "R4 R5");
    idle(4);

    // short latency directed cases
    lat_short = 1'b1;
    kcyc(2, 6'd41, 16'h7777, 16'h8888, 2'b10, 2'b11, "R3");
    kcyc(1, 6'd41, '0, '0, '0, '0, "R6 R7");
    kcyc(1, 6'd40, '0, '0, '0, '0, "R4 R7");
    kcyc(2, 6'd41, 16'h9999, 16'hAAAA, 2'b01, 2'b00, "R3");
    kcyc(2, 6'd40, 16'hBBBB, 16'hCCCC, 2'b11, 2'b01, "R3");
    kcyc(1, 6'd40, '0, '0, '0, '0, "R7");
    kcyc(1, 6'd2, '0, '0, '0, '0, "R6");
    idle(4);

    rnd_run(400);
    idle(4);
    lat_short = 1'b0;
    rnd_run(400);
    idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule